// File: doc/BRIEF.md
# Burst Beat Address and Byte-Lane Walker

This block steps through one memory-bus burst, one beat at a time. A load strobe captures the start address, a 3-bit beat-size code, a beats-minus-one length field and a 2-bit burst kind. The block checks these values when it takes them. If they are valid, it then presents the first beat: the byte address, the lowest and highest active byte lanes of the data bus, a write-strobe mask covering exactly those lanes, and a flag that marks the final beat.

Each advance pulse moves the outputs to the next beat. The address stays put, steps by the beat size, or steps and folds back inside a wrap window, depending on the burst kind. An unaligned start address narrows only the lanes of the beats that carry it. The data bus width, the address width and the length-field width are parameters. Every output is registered, so each load or advance shows up at the outputs one clock later. A load that cannot be carried out is refused: the block stays idle and raises an error output.

Top module: `burst_walker`

## Requirements
- R1: After reset, busy, err, last and strobe are all 0.
- R2: A load while idle with a valid setup makes busy 1 one cycle later, with beat_addr equal to the start address and err equal to 0.
- R3: While busy, lane_lo equals beat_addr modulo BUS_BYTES. lane_hi equals the last byte of the size-aligned slot that holds lane_lo, that is lane_lo with its low size-code bits forced to 1. strobe sets exactly bits lane_lo through lane_hi inclusive.
- R4: With kind code 2'b00 (hold), every beat keeps the start address, so every beat repeats the first beat's lanes.
- R5: With kind code 2'b01 (step), each beat after the first sits at the previous address aligned down to 2^size bytes, plus 2^size.
- R6: With kind code 2'b10 (loop), the window spans (len+1)·2^size bytes, and its lower edge is the start address aligned down to that span. Each step adds 2^size to the aligned address. Reaching the upper edge returns the address to the lower edge.
- R7: last is 1 exactly on the beat whose index equals the length field. An advance on that beat returns the block to idle one cycle later, with busy, last and strobe at 0.
- R8: A load with kind code 2'b11 is refused: err is 1 one cycle later and busy stays 0.
- R9: A load with kind 2'b10 and a length field other than 1, 3, 7 or 15 (2, 4, 8 or 16 beats) is refused the same way.
- R10: A load whose beat of 2^size bytes is wider than BUS_BYTES is refused the same way.
- R11: A load while busy has no effect on the beat outputs, and an advance while idle leaves the block idle.
- R12: The next accepted load clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture a new burst setup (acted on only while idle) |
| start_addr | input | ADDR_W | First byte address of the burst |
| size_code | input | 3 | Beat size, 2^size_code bytes |
| len | input | LEN_W | Number of beats minus one |
| kind | input | 2 | 00 hold, 01 step, 10 loop, 11 refused |
| advance | input | 1 | Move to the next beat (acted on only while busy) |
| busy | output | 1 | A burst is in progress |
| err | output | 1 | The last load attempt was refused |
| beat_addr | output | ADDR_W | Address of the current beat |
| lane_lo | output | LANE_W | Lowest active byte lane |
| lane_hi | output | LANE_W | Highest active byte lane |
| strobe | output | BUS_BYTES | Byte-enable mask for the current beat |
| last | output | 1 | Current beat is the final one |

## Verification
The sweep walks every kind, every legal size and every start offset within two bus words, for lengths of 1 to 16 beats. It therefore reaches unaligned first beats, narrow beats inside a wide bus, and loop windows entered partway along. A design that failed to align before stepping would carry the unaligned offset into every later beat. A wrong window edge would fold back too early or run past the window. A lane mask that was off by one would drop or add a byte at the slot end. Refused setups, loads during a burst and advances while idle are driven on purpose, to catch a design that starts a bad burst or lets a stray load overwrite a burst in progress.

// File: rtl/burst_walker_pkg.sv
package burst_walker_pkg;
  typedef enum logic [1:0] {
    BK_HOLD = 2'b00,
    BK_STEP = 2'b01,
    BK_LOOP = 2'b10,
    BK_BAD  = 2'b11
  } burst_kind_e;
endpackage

// File: rtl/burst_cfg_check.sv
module burst_cfg_check #(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int BUS_BYTES = 4
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        size_code,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        kind,
  output logic              cfg_ok,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi
);
  import burst_walker_pkg::*;
  localparam int LANE_W = $clog2(BUS_BYTES);

  logic [ADDR_W-1:0] span;
  logic              len_ok, size_ok, kind_ok;

  always_comb begin
    span    = ({{(ADDR_W-LEN_W){1'b0}}, len} + ADDR_W'(1)) << size_code;
    win_lo  = start_addr & ~(span - ADDR_W'(1));
    win_hi  = win_lo + span;
    len_ok  = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
              (len == LEN_W'(7)) || (len == LEN_W'(15));
    size_ok = ({29'd0, size_code} <= LANE_W);
    kind_ok = (kind != BK_BAD);
    cfg_ok  = kind_ok && size_ok && ((kind != BK_LOOP) || len_ok);
  end
endmodule

// File: rtl/burst_step.sv
module burst_step #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size_code,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  output logic [ADDR_W-1:0] next_addr
);
  import burst_walker_pkg::*;

  logic [ADDR_W-1:0] beat_bytes, aligned, bumped;

  always_comb begin
    beat_bytes = ADDR_W'(1) << size_code;
    aligned    = cur_addr & ~(beat_bytes - ADDR_W'(1));
    bumped     = aligned + beat_bytes;
    case (kind)
      BK_HOLD: next_addr = cur_addr;
      BK_LOOP: next_addr = (bumped == win_hi) ? win_lo : bumped;
      default: next_addr = bumped;
    endcase
  end
endmodule

// File: rtl/burst_lanes.sv
module burst_lanes #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 4,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [2:0]           size_code,
  output logic [LANE_W-1:0]    lo,
  output logic [LANE_W-1:0]    hi,
  output logic [BUS_BYTES-1:0] mask
);
  logic [LANE_W:0] fill;

  always_comb begin
    fill = (LANE_W+1)'((1 << size_code) - 1);
    lo   = addr[LANE_W-1:0];
    hi   = lo | fill[LANE_W-1:0];
  end

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
    assign mask[b] = (LANE_W'(b) >= lo) && (LANE_W'(b) <= hi);
  end
endmodule

// File: rtl/burst_walker.sv
module burst_walker #(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int BUS_BYTES = 4,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [2:0]           size_code,
  input  logic [LEN_W-1:0]     len,
  input  logic [1:0]           kind,
  input  logic                 advance,
  output logic                 busy,
  output logic                 err,
  output logic [ADDR_W-1:0]    beat_addr,
  output logic [LANE_W-1:0]    lane_lo,
  output logic [LANE_W-1:0]    lane_hi,
  output logic [BUS_BYTES-1:0] strobe,
  output logic                 last
);
  logic              cfg_ok, take;
  logic [ADDR_W-1:0] cfg_lo, cfg_hi, win_lo_q, win_hi_q, step_addr, sel_addr;
  logic [2:0]        size_q, sel_size;
  logic [1:0]        kind_q;
  logic [LEN_W-1:0]  len_q, beat_cnt;
  logic [LANE_W-1:0] n_lo, n_hi;
  logic [BUS_BYTES-1:0] n_mask;

  burst_cfg_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_cfg (
    .start_addr(start_addr), .size_code(size_code), .len(len), .kind(kind),
    .cfg_ok(cfg_ok), .win_lo(cfg_lo), .win_hi(cfg_hi)
  );

  burst_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr(beat_addr), .size_code(size_q), .kind(kind_q),
    .win_lo(win_lo_q), .win_hi(win_hi_q), .next_addr(step_addr)
  );

  assign take     = !busy && load && cfg_ok;
  assign sel_addr = take ? start_addr : step_addr;
  assign sel_size = take ? size_code : size_q;

  burst_lanes #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_lanes (
    .addr(sel_addr), .size_code(sel_size), .lo(n_lo), .hi(n_hi), .mask(n_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      err       <= 1'b0;
      last      <= 1'b0;
      strobe    <= '0;
      beat_addr <= '0;
      lane_lo   <= '0;
      lane_hi   <= '0;
      beat_cnt  <= '0;
      len_q     <= '0;
      size_q    <= '0;
      kind_q    <= '0;
      win_lo_q  <= '0;
      win_hi_q  <= '0;
    end else if (!busy && load) begin
      err <= !cfg_ok;
      if (cfg_ok) begin
        busy      <= 1'b1;
        len_q     <= len;
        size_q    <= size_code;
        kind_q    <= kind;
        win_lo_q  <= cfg_lo;
        win_hi_q  <= cfg_hi;
        beat_cnt  <= '0;
        beat_addr <= sel_addr;
        lane_lo   <= n_lo;
        lane_hi   <= n_hi;
        strobe    <= n_mask;
        last      <= (len == '0);
      end
    end else if (busy && advance) begin
      if (last) begin
        busy   <= 1'b0;
        last   <= 1'b0;
        strobe <= '0;
      end else begin
        beat_cnt  <= beat_cnt + LEN_W'(1);
        beat_addr <= sel_addr;
        lane_lo   <= n_lo;
        lane_hi   <= n_hi;
        strobe    <= n_mask;
        last      <= ((beat_cnt + LEN_W'(1)) == len_q);
      end
    end
  end
endmodule

// File: rtl/burst_walker_chk.sv
module burst_walker_chk #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 4,
  localparam int LANE_W   = $clog2(BUS_BYTES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 load,
  input logic                 advance,
  input logic [1:0]           kind,
  input logic                 busy,
  input logic                 err,
  input logic                 last,
  input logic [ADDR_W-1:0]    beat_addr,
  input logic [LANE_W-1:0]    lane_lo,
  input logic [LANE_W-1:0]    lane_hi,
  input logic [BUS_BYTES-1:0] strobe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !err && !last && strobe == '0));

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(strobe) == int'(lane_hi) - int'(lane_lo) + 1));

  assert_lane_start_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (lane_lo == beat_addr[LANE_W-1:0]));

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && last && advance) |=> !busy);

  assert_mid_continues_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && advance) |=> busy);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (strobe == '0 && !last));

  assert_bad_kind_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && load && kind == 2'b11) |=> (err && !busy));

  assert_load_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && load && !advance) |=> ($stable(beat_addr) && $stable(strobe) && busy));

  assert_idle_advance_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> !busy);
endmodule

bind burst_walker burst_walker_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk(clk), .rst(rst), .load(load), .advance(advance), .kind(kind),
  .busy(busy), .err(err), .last(last), .beat_addr(beat_addr),
  .lane_lo(lane_lo), .lane_hi(lane_hi), .strobe(strobe)
);

// File: tb/burst_walker_test.sv
`timescale 1ns/1ps
module burst_walker_test;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int BB = 4;
  localparam int LN = $clog2(BB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic advance = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0]    size_code = '0;
  logic [LW-1:0] len = '0;
  logic [1:0]    kind = '0;
  logic busy, err, last;
  logic [AW-1:0] beat_addr;
  logic [LN-1:0] lane_lo, lane_hi;
  logic [BB-1:0] strobe;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_walker #(.ADDR_W(AW), .LEN_W(LW), .BUS_BYTES(BB)) uut (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .size_code(size_code), .len(len), .kind(kind), .advance(advance),
    .busy(busy), .err(err), .beat_addr(beat_addr), .lane_lo(lane_lo),
    .lane_hi(lane_hi), .strobe(strobe), .last(last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mask(input int addr, input int sz);
    int lo = addr % BB;
    int hi = (lo / sz) * sz + sz - 1;
    int m = 0;
    for (int b = 0; b < BB; b++) if (b >= lo && b <= hi) m |= (1 << b);
    return m;
  endfunction

  task automatic do_load(input int a, input int s, input int l, input int t);
    @(negedge clk);
    load = 1'b1; start_addr = AW'(a); size_code = 3'(s); len = LW'(l); kind = 2'(t);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_burst(input int a, input int s, input int l, input int t);
    int sz = 1 << s;
    int total = (l + 1) * sz;
    int lower = a - (a % total);
    int algn = a - (a % sz);
    int ea;
    do_load(a, s, l, t);
    check(busy === 1'b1, "R2 busy after load", busy, 1);
    check(err === 1'b0, "R12 err cleared by accepted load", err, 0);
    for (int i = 0; i <= l; i++) begin
      if (i == 0 || t == 0) ea = a;
      else if (t == 1) ea = algn + i * sz;
      else ea = lower + ((algn - lower) + i * sz) % total;
      if (t == 0) check(int'(beat_addr) == ea, "R4 hold address", int'(beat_addr), ea);
      else if (t == 1) check(int'(beat_addr) == ea, "R5 step address", int'(beat_addr), ea);
      else check(int'(beat_addr) == ea, "R6 loop address", int'(beat_addr), ea);
      check(int'(strobe) == exp_mask(ea, sz), "R3 strobe lanes", int'(strobe), exp_mask(ea, sz));
      check(last === (i == l), "R7 last flag", int'(last), int'(i == l));
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
    check(busy === 1'b0 && strobe == '0 && last === 1'b0, "R7 idle after last",
          int'({busy, last, strobe}), 0);
  endtask

  task automatic run_reject(input int a, input int s, input int l, input int t, input string tag);
    do_load(a, s, l, t);
    check(err === 1'b1, tag, err, 1);
    check(busy === 1'b0 && strobe == '0, tag, int'({busy, strobe}), 0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(busy === 1'b0, "R11 advance while idle", busy, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lens[5] = '{0, 1, 3, 7, 15};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && err === 1'b0 && last === 1'b0 && strobe == '0,
          "R1 reset state", int'({busy, err, last, strobe}), 0);

    for (int t = 0; t < 3; t++)
      for (int s = 0; s <= LN; s++)
        for (int off = 0; off < 8; off++)
          for (int li = 0; li < 5; li++)
            if (!(t == 2 && lens[li] == 0))
              run_burst(16'h1230 + off, s, lens[li], t);

    run_reject(16'h0040, 2, 3, 3, "R8 reserved kind refused");
    run_burst(16'h0041, 1, 1, 1);
    run_reject(16'h0080, 2, 2, 2, "R9 loop length 3 beats refused");
    run_reject(16'h0080, 1, 0, 2, "R9 loop length 1 beat refused");
    run_burst(16'h0084, 2, 3, 2);
    run_reject(16'h0100, 3, 1, 1, "R10 beat wider than bus refused");
    run_burst(16'h0100, 2, 0, 0);

    do_load(16'h0200, 2, 3, 1);
    @(negedge clk);
    load = 1'b1; start_addr = 16'h0500; kind = 2'b00; len = '0;
    @(negedge clk);
    load = 1'b0;
    check(beat_addr == 16'h0200 && busy === 1'b1 && last === 1'b0,
          "R11 load while busy ignored", int'(beat_addr), 16'h0200);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(beat_addr == 16'h0204, "R11 burst continues after stray load", int'(beat_addr), 16'h0204);
    repeat (3) begin
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
    check(busy === 1'b0, "R7 idle after stray-load burst", busy, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule